// File: doc/BRIEF.md
# Single-Bit Memory Operation Unit

This unit executes the single-bit instruction group of a small 4-bit controller. It accepts a decoded operation together with an addressing mode and its operand fields, forms a nibble address and a bit index, and then works through a nibble-wide data memory port. It can force a bit high or low. It can test a bit and request a skip of the following instruction. It can test a bit, clear it and skip in one pass. It can also fold a bit into the carry flag with AND, OR or XOR.

The sequencer raises `start` for one cycle while the unit is idle. The unit performs a synchronous read in its first busy cycle and a write-back in its second. It then reports the skip request, the illegal-combination flag and the cycle count, qualified by a one-cycle `done` pulse. When a skip is taken, the unit stays busy for as many extra cycles as the skipped instruction is long. The sequencer supplies that length on `nextLen` together with `start`.

Top module: `bitOpUnit`

## Requirements
- R1: Operation code 0 (set) writes the addressed nibble back with the selected bit at 1, and code 1 (clear) writes it back with that bit at 0. The other three bits of the nibble are left as they were.
- R2: Code 2 requests a skip when the addressed bit is 1. Code 3 requests a skip when the addressed bit is 0. Neither changes memory.
- R3: Code 4 requests a skip when the addressed bit is 1 and writes the nibble back with that bit cleared.
- R4: Codes 5, 6 and 7 set carry to carry AND, OR or XOR the addressed bit respectively. They never assert the memory write strobe.
- R5: Mode 0 addresses operand[7:0] with bit index `bitSel`. Mode 1 addresses {3'b111, operand[4], operand[3:0]}, which gives two 16-nibble windows at 0xE0 and 0xF0, with bit index `bitSel`. Mode 2 addresses {operand[7:2], regL[3:2]} with bit index regL[1:0]. Mode 3 addresses {regH, operand[3:0]} with bit index `bitSel`.
- R6: A legal operation asserts `memRe` with the address in the cycle after `start` is sampled. Any write-back happens in the following cycle. `done` rises in the cycle after that unless a skip extends the operation.
- R7: `cycles` reports 2 plus S, where S is `nextLen` when a skip is requested and 0 otherwise. `busy` stays high for the S extra cycles, which delays `done` by S cycles.
- R8: Codes 4 to 7 in mode 0 are illegal. The unit raises `illegal` with `done` in the cycle after `start`, reports `cycles` as 0, requests no skip, leaves carry unchanged and asserts neither memory strobe.
- R9: Carry is 0 after a synchronous reset and changes only on codes 5, 6 and 7.
- R10: A `start` presented while `busy` is high is ignored and has no effect on memory or on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op | input | 3 | Operation code |
| mode | input | 2 | Addressing mode |
| operand | input | 8 | Address operand field of the instruction |
| bitSel | input | 2 | Bit index from the instruction |
| regH | input | 4 | H register value |
| regL | input | 4 | L register value |
| nextLen | input | 2 | Length in cycles of the following instruction |
| memAddr | output | 8 | Data memory nibble address |
| memRe | output | 1 | Data memory read strobe |
| memRdata | input | 4 | Read data, valid the cycle after `memRe` |
| memWe | output | 1 | Data memory write strobe |
| memWdata | output | 4 | Write data |
| carry | output | 1 | Carry flag |
| skipReq | output | 1 | Skip request, valid with `done` |
| illegal | output | 1 | Illegal combination flag, valid with `done` |
| cycles | output | 3 | Machine cycles used, valid with `done` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting the edge that samples `start` as edge 0, the memory address and read strobe are due in the cycle after edge 0. The write strobe is due in the cycle after edge 1. Carry, memory contents and the result flags are settled after edge 2, and `done` appears after edge 2 + S, or after edge 0 for an illegal combination. The driver pushes each expected record into a queue and stamps the cycle on which `start` was presented. The monitor pops a record on every `done` and compares the measured latency as well as the values. Read and write strobes are counted on clock edges over each operation, so a stray or missing write-back is caught even when it would store an unchanged value.

// File: rtl/bitOpPkg.sv
package bitOpPkg;

  typedef enum logic [2:0] {
    OP_SET    = 3'd0,
    OP_CLR    = 3'd1,
    OP_SKT    = 3'd2,
    OP_SKF    = 3'd3,
    OP_SKTCLR = 3'd4,
    OP_AND    = 3'd5,
    OP_OR     = 3'd6,
    OP_XOR    = 3'd7
  } bitOp_e;

  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_WINDOW = 2'd1,
    AM_PAIRL  = 2'd2,
    AM_HPAGE  = 2'd3
  } addrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address and bit index
    logic readEn;   // cycle 1: read request
    logic writeEn;  // cycle 2: write back
    logic carryEn;  // cycle 2: update carry
  } strobes_t;

  function automatic logic isLegal(bitOp_e op, addrMode_e m);
    return !(m == AM_DIRECT && (op inside {OP_SKTCLR, OP_AND, OP_OR, OP_XOR}));
  endfunction

endpackage

// File: rtl/bitOpCtrl.sv
module bitOpCtrl
  import bitOpPkg::*;
#(
  parameter int LEN_W = 2,
  localparam int CYC_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  bitOp_e           op,
  input  addrMode_e        mode,
  input  logic [LEN_W-1:0] nextLen,
  input  logic             bitVal,
  output strobes_t         strb,
  output bitOp_e           opQ,
  output logic             busy,
  output logic             done,
  output logic             skipReq,
  output logic             illegal,
  output logic [CYC_W-1:0] cycles
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EXEC, S_SKIP} state_e;

  state_e           state;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] remQ;
  logic             doneQ;
  logic             skipQ;
  logic             illQ;
  logic [CYC_W-1:0] cycQ;
  logic             legal;
  logic             skipHit;

  assign legal = isLegal(op, mode);

  always_comb begin
    strb.capture = (state == S_IDLE) && start && legal;
    strb.readEn  = (state == S_READ);
    strb.writeEn = (state == S_EXEC) && (opQ inside {OP_SET, OP_CLR, OP_SKTCLR});
    strb.carryEn = (state == S_EXEC) && (opQ inside {OP_AND, OP_OR, OP_XOR});
    skipHit = (state == S_EXEC) &&
              (((opQ == OP_SKT || opQ == OP_SKTCLR) && bitVal) ||
               ((opQ == OP_SKF) && !bitVal));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      opQ   <= OP_SET;
      lenQ  <= '0;
      remQ  <= '0;
      doneQ <= 1'b0;
      skipQ <= 1'b0;
      illQ  <= 1'b0;
      cycQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            skipQ <= 1'b0;
            cycQ  <= '0;
            if (legal) begin
              opQ   <= op;
              lenQ  <= nextLen;
              illQ  <= 1'b0;
              state <= S_READ;
            end else begin
              illQ  <= 1'b1;
              doneQ <= 1'b1;
            end
          end
        end
        S_READ: state <= S_EXEC;
        S_EXEC: begin
          skipQ <= skipHit;
          if (skipHit && lenQ != '0) begin
            cycQ  <= CYC_W'(2) + CYC_W'(lenQ);
            remQ  <= lenQ;
            state <= S_SKIP;
          end else begin
            cycQ  <= CYC_W'(2);
            doneQ <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_SKIP: begin
          remQ <= remQ - 1'b1;
          if (remQ == LEN_W'(1)) begin
            doneQ <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = doneQ;
  assign skipReq = skipQ;
  assign illegal = illQ;
  assign cycles  = cycQ;

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    strb.writeEn |-> $past(strb.readEn)); // R6
  AST_LEGAL_CYCLES: assert property (@(posedge clk) disable iff (rst)
    (doneQ && !illQ) |-> (cycQ >= CYC_W'(2))); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (doneQ && illQ) |-> (!skipQ && cycQ == '0)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(opQ)); // R10

endmodule

// File: rtl/bitOpPath.sv
module bitOpPath
  import bitOpPkg::*;
#(
  parameter int NIB_W = 4,
  localparam int ADDR_W = 2 * NIB_W,
  localparam int BIT_W = $clog2(NIB_W),
  localparam int WIN_ONES = ADDR_W - NIB_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  bitOp_e            opQ,
  input  addrMode_e         mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic [NIB_W-1:0]  regH,
  input  logic [NIB_W-1:0]  regL,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  input  logic [NIB_W-1:0]  memRdata,
  output logic              memWe,
  output logic [NIB_W-1:0]  memWdata,
  output logic              bitVal,
  output logic              carry
);

  logic [ADDR_W-1:0] addrNext, addrQ;
  logic [BIT_W-1:0]  bitNext, bitQ;
  logic [NIB_W-1:0]  mask;
  logic              carryQ;

  // Address and bit-index formation per mode
  always_comb begin
    addrNext = operand;
    bitNext  = bitSel;
    unique case (mode)
      AM_DIRECT: addrNext = operand;
      AM_WINDOW: addrNext = {{WIN_ONES{1'b1}}, operand[NIB_W], operand[NIB_W-1:0]};
      AM_PAIRL: begin
        addrNext = {operand[ADDR_W-1:BIT_W], regL[NIB_W-1:BIT_W]};
        bitNext  = regL[BIT_W-1:0];
      end
      AM_HPAGE:  addrNext = {regH, operand[NIB_W-1:0]};
      default:   addrNext = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      bitQ  <= '0;
    end else if (strb.capture) begin
      addrQ <= addrNext;
      bitQ  <= bitNext;
    end
  end

  assign mask     = NIB_W'(1) << bitQ;
  assign bitVal   = memRdata[bitQ];
  assign memAddr  = addrQ;
  assign memRe    = strb.readEn;
  assign memWe    = strb.writeEn;
  assign memWdata = (opQ == OP_SET) ? (memRdata | mask) : (memRdata & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      carryQ <= 1'b0;
    end else if (strb.carryEn) begin
      unique case (opQ)
        OP_AND:  carryQ <= carryQ & bitVal;
        OP_OR:   carryQ <= carryQ | bitVal;
        OP_XOR:  carryQ <= carryQ ^ bitVal;
        default: carryQ <= carryQ;
      endcase
    end
  end

  assign carry = carryQ;

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.carryEn |=> $stable(carryQ)); // R9
  AST_WRITE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    strb.writeEn |-> $past(strb.capture, 2)); // R6
  AST_LOGIC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    strb.carryEn |-> !memWe); // R4

endmodule

// File: rtl/bitOpUnit.sv
module bitOpUnit
  import bitOpPkg::*;
#(
  parameter int NIB_W = 4,
  parameter int LEN_W = 2,
  localparam int ADDR_W = 2 * NIB_W,
  localparam int BIT_W = $clog2(NIB_W),
  localparam int CYC_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] operand,
  input  logic [BIT_W-1:0]  bitSel,
  input  logic [NIB_W-1:0]  regH,
  input  logic [NIB_W-1:0]  regL,
  input  logic [LEN_W-1:0]  nextLen,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  input  logic [NIB_W-1:0]  memRdata,
  output logic              memWe,
  output logic [NIB_W-1:0]  memWdata,
  output logic              carry,
  output logic              skipReq,
  output logic              illegal,
  output logic [CYC_W-1:0]  cycles,
  output logic              busy,
  output logic              done
);

  strobes_t strb;
  bitOp_e   opQ;
  logic     bitVal;

  bitOpCtrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (bitOp_e'(op)),
    .mode    (addrMode_e'(mode)),
    .nextLen (nextLen),
    .bitVal  (bitVal),
    .strb    (strb),
    .opQ     (opQ),
    .busy    (busy),
    .done    (done),
    .skipReq (skipReq),
    .illegal (illegal),
    .cycles  (cycles)
  );

  bitOpPath #(.NIB_W(NIB_W)) i_path (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .opQ      (opQ),
    .mode     (addrMode_e'(mode)),
    .operand  (operand),
    .bitSel   (bitSel),
    .regH     (regH),
    .regL     (regL),
    .memAddr  (memAddr),
    .memRe    (memRe),
    .memRdata (memRdata),
    .memWe    (memWe),
    .memWdata (memWdata),
    .bitVal   (bitVal),
    .carry    (carry)
  );

endmodule

// File: tb/test_bitOpUnit.sv
module test_bitOpUnit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] mode = '0;
  logic [7:0] operand = '0;
  logic [1:0] bitSel = '0;
  logic [3:0] regH = '0;
  logic [3:0] regL = '0;
  logic [1:0] nextLen = '0;
  logic [7:0] memAddr;
  logic       memRe;
  logic [3:0] memRdata;
  logic       memWe;
  logic [3:0] memWdata;
  logic       carry, skipReq, illegal, busy, done;
  logic [2:0] cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitOpUnit i_bitOpUnit (
    .clk(clk), .rst(rst), .start(start), .op(op), .mode(mode),
    .operand(operand), .bitSel(bitSel), .regH(regH), .regL(regL),
    .nextLen(nextLen), .memAddr(memAddr), .memRe(memRe),
    .memRdata(memRdata), .memWe(memWe), .memWdata(memWdata),
    .carry(carry), .skipReq(skipReq), .illegal(illegal),
    .cycles(cycles), .busy(busy), .done(done)
  );

  // Data memory model: synchronous read, write strobe
  logic [3:0] mem [256];
  logic [3:0] rdReg = '0;
  assign memRdata = rdReg;
  always @(posedge clk) begin
    if (memRe) rdReg <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWdata;
  end

  logic [3:0] refMem [256];
  logic       refCarry = 1'b0;
  int checks = 0;
  int errors = 0;
  int cycCnt = 0;
  int startCyc = 0;
  int reCnt = 0;
  int weCnt = 0;
  bit countReset = 0;

  typedef struct {
    logic       skip;
    logic       ill;
    logic [2:0] cyc;
    logic       cy;
    logic [7:0] addr;
    logic [3:0] nib;
    int         lat;
    int         nRe;
    int         nWe;
    string      tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycCnt <= cycCnt + 1;
    if (countReset) begin
      reCnt <= 0;
      weCnt <= 0;
    end else begin
      if (memRe) reCnt <= reCnt + 1;
      if (memWe) weCnt <= weCnt + 1;
    end
  end

  // Monitor: pop and compare on each done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(skipReq == e.skip, {e.tag, " skip"}, int'(skipReq), int'(e.skip));
        chk(illegal == e.ill, "R8 illegal flag", int'(illegal), int'(e.ill));
        chk(cycles == e.cyc, "R7 cycles", int'(cycles), int'(e.cyc));
        chk(carry == e.cy, {e.tag, " carry"}, int'(carry), int'(e.cy));
        chk(cycCnt - startCyc == e.lat, "R6 R7 done latency", cycCnt - startCyc, e.lat);
        chk(reCnt == e.nRe, "R6 read strobes", reCnt, e.nRe);
        chk(weCnt == e.nWe, {e.tag, " write strobes"}, weCnt, e.nWe);
        if (!e.ill)
          chk(mem[e.addr] == e.nib, {e.tag, " nibble"}, int'(mem[e.addr]), int'(e.nib));
      end
    end
  end

  function automatic logic [7:0] refAddr(input logic [1:0] m, input logic [7:0] opd,
                                         input logic [3:0] h, input logic [3:0] l);
    case (m)
      2'd0:    return opd;
      2'd1:    return {3'b111, opd[4], opd[3:0]};
      2'd2:    return {opd[7:2], l[3:2]};
      default: return {h, opd[3:0]};
    endcase
  endfunction

  task automatic runOp(input logic [2:0] o, input logic [1:0] m, input logic [7:0] opd,
                       input logic [1:0] bs, input logic [3:0] h, input logic [3:0] l,
                       input logic [1:0] nl, input string tag, input bit poke);
    exp_t e;
    logic [7:0] a;
    logic [1:0] b;
    logic bv, lg, sk;
    int w;
    a  = refAddr(m, opd, h, l);
    b  = (m == 2'd2) ? l[1:0] : bs;
    lg = !(m == 2'd0 && o >= 3'd4);
    bv = refMem[a][b];
    sk = lg && (((o == 3'd2 || o == 3'd4) && bv) || (o == 3'd3 && !bv));
    if (lg) begin
      if (o == 3'd0) refMem[a][b] = 1'b1;
      if (o == 3'd1 || o == 3'd4) refMem[a][b] = 1'b0;
      if (o == 3'd5) refCarry = refCarry & bv;
      if (o == 3'd6) refCarry = refCarry | bv;
      if (o == 3'd7) refCarry = refCarry ^ bv;
    end
    e.skip = sk;
    e.ill  = !lg;
    e.cyc  = lg ? (3'd2 + (sk ? 3'(nl) : 3'd0)) : 3'd0;
    e.cy   = refCarry;
    e.addr = a;
    e.nib  = refMem[a];
    e.lat  = (lg ? int'(e.cyc) : 0) + 1;
    e.nRe  = lg ? 1 : 0;
    e.nWe  = (lg && (o == 3'd0 || o == 3'd1 || o == 3'd4)) ? 1 : 0;
    e.tag  = tag;
    q.push_back(e);

    @(negedge clk);
    op = o; mode = m; operand = opd; bitSel = bs; regH = h; regL = l; nextLen = nl;
    start = 1'b1;
    countReset = 1'b1;
    startCyc = cycCnt;
    @(negedge clk);
    countReset = 1'b0;
    start = 1'b0;
    if (lg) begin
      chk(memRe == 1'b1, "R6 read in first cycle", int'(memRe), 1);
      chk(memAddr == a, {"R5 address ", tag}, int'(memAddr), int'(a));
    end else begin
      chk(memRe == 1'b0, "R8 no read", int'(memRe), 0);
    end
    if (poke) begin
      op = 3'd0; mode = 2'd0; operand = 8'h80; bitSel = 2'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (q.size() != 0 && w < 60) begin
      @(negedge clk);
      w++;
    end
    if (w >= 60) chk(1'b0, "R6 done never arrived", 0, 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 4'((i * 7 + 3) & 15);
      refMem[i] = 4'((i * 7 + 3) & 15);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(carry == 1'b0, "R9 carry after reset", int'(carry), 0);
    chk(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R6 done after reset", int'(done), 0);
    chk(memWe == 1'b0 && memRe == 1'b0, "R6 strobes after reset", int'(memWe | memRe), 0);

    // R1 / R5: set and clear across all modes
    runOp(3'd0, 2'd0, 8'h12, 2'd2, 4'h0, 4'h0, 2'd1, "R1 set direct", 0);
    runOp(3'd1, 2'd1, 8'h15, 2'd0, 4'h0, 4'h0, 2'd1, "R1 clear window high", 0);
    runOp(3'd0, 2'd1, 8'h05, 2'd3, 4'h0, 4'h0, 2'd1, "R1 set window low", 0);
    runOp(3'd0, 2'd2, 8'h34, 2'd0, 4'h0, 4'hE, 2'd1, "R1 set pairL", 0);
    runOp(3'd1, 2'd3, 8'h07, 2'd3, 4'hA, 4'h0, 2'd1, "R1 clear hpage", 0);

    // R2 / R7: tests with and without skip, both lengths
    runOp(3'd0, 2'd0, 8'h40, 2'd1, 4'h0, 4'h0, 2'd1, "R1 prep", 0);
    runOp(3'd2, 2'd0, 8'h40, 2'd1, 4'h0, 4'h0, 2'd1, "R2 true hit len1", 0);
    runOp(3'd3, 2'd0, 8'h40, 2'd1, 4'h0, 4'h0, 2'd2, "R2 false miss", 0);
    runOp(3'd1, 2'd0, 8'h40, 2'd1, 4'h0, 4'h0, 2'd1, "R1 prep", 0);
    runOp(3'd3, 2'd3, 8'h00, 2'd1, 4'h4, 4'h0, 2'd2, "R2 false hit len2", 0);
    runOp(3'd2, 2'd2, 8'h40, 2'd0, 4'h0, 4'h1, 2'd2, "R2 true miss", 0);

    // R3: test-and-clear, then repeat on the now-clear bit
    runOp(3'd0, 2'd3, 8'h09, 2'd0, 4'h5, 4'h0, 2'd1, "R1 prep", 0);
    runOp(3'd4, 2'd3, 8'h09, 2'd0, 4'h5, 4'h0, 2'd2, "R3 test clear hit", 0);
    runOp(3'd4, 2'd3, 8'h09, 2'd0, 4'h5, 4'h0, 2'd2, "R3 test clear miss", 0);
    runOp(3'd4, 2'd1, 8'h12, 2'd1, 4'h0, 4'h0, 2'd1, "R3 test clear window", 0);

    // R4 / R9: carry logic
    runOp(3'd0, 2'd1, 8'h1A, 2'd2, 4'h0, 4'h0, 2'd1, "R1 prep", 0);
    runOp(3'd1, 2'd1, 8'h1B, 2'd2, 4'h0, 4'h0, 2'd1, "R1 prep", 0);
    runOp(3'd5, 2'd1, 8'h1A, 2'd2, 4'h0, 4'h0, 2'd1, "R4 and from zero", 0);
    runOp(3'd6, 2'd1, 8'h1A, 2'd2, 4'h0, 4'h0, 2'd1, "R4 or sets", 0);
    runOp(3'd5, 2'd1, 8'h1A, 2'd2, 4'h0, 4'h0, 2'd1, "R4 and keeps", 0);
    runOp(3'd7, 2'd3, 8'h0B, 2'd2, 4'hF, 4'h0, 2'd1, "R4 xor with zero", 0);
    runOp(3'd7, 2'd1, 8'h1A, 2'd2, 4'h0, 4'h0, 2'd1, "R4 xor clears", 0);
    runOp(3'd6, 2'd2, 8'hF8, 2'd0, 4'h0, 4'hE, 2'd1, "R4 or pairL", 0);
    runOp(3'd0, 2'd0, 8'h33, 2'd3, 4'h0, 4'h0, 2'd1, "R9 carry held on set", 0);

    // R8: illegal combinations
    runOp(3'd5, 2'd0, 8'h1A, 2'd2, 4'h0, 4'h0, 2'd1, "R8 and direct", 0);
    runOp(3'd4, 2'd0, 8'h40, 2'd1, 4'h0, 4'h0, 2'd1, "R8 test clear direct", 0);

    // R10: start while busy is ignored
    runOp(3'd3, 2'd0, 8'h40, 2'd1, 4'h0, 4'h0, 2'd2, "R10 busy start", 1);
    chk(mem[8'h80] == refMem[8'h80], "R10 poked nibble", int'(mem[8'h80]), int'(refMem[8'h80]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule